// File: doc/BRIEF.md
# Pairwise Squared-Difference Minimum Search

The block compares two small arrays of signed samples. A start pulse tells it that both arrays are loaded. It then visits every combination of a first-array entry and a second-array entry, one combination per clock, in row-major order. The row is the first-array index and the column is the second-array index. A single shared unit squares the difference of each pair. For each row, a running minimum keeps the smallest square seen so far. That minimum is written to the output array when the row's last column is processed.

A scan takes exactly LEN*LEN busy cycles. When it ends, a done flag rises and stays up until the next start pulse. The flag also clears on a synchronous reset. The caller must hold both input arrays steady from the start pulse until done rises, because the block reads them directly and does not keep a copy.

Top module: `pair_min_search`

## Requirements
- R1: While `rst` is high on a rising edge, `busy` and `done` become 0 and every output row becomes 0. This holds even in the middle of a scan.
- R2: While idle (`busy`=0), changes on `arrA`/`arrB` have no effect on `minFlat`, `busy` or `done`. Only a start pulse begins work.
- R3: When `start` is sampled while idle, `busy` is 1 after that edge and stays 1 for exactly LEN*LEN cycles. On the edge that ends the scan, `busy` falls and `done` rises. `busy` and `done` are never both 1.
- R4: After a scan, row k of `minFlat` (bits [k*3N +: 3N]) holds the minimum over all l of (a[k]-b[l])², zero-extended to 3N bits. Elements are two's-complement, element i at bits [i*N +: N].
- R5: Extreme inputs do not overflow. A difference of 127-(-128) with N=8 gives 65025.
- R6: `done` stays 1 while `start` is low. A start pulse while done clears `done` and begins a new scan.
- R7: A start pulse while `busy` is ignored. The scan still ends LEN*LEN cycles after the start that launched it.
- R8: Row k of `minFlat` changes only on the edge that processes column LEN-1 of row k. That edge is LEN*(k+1) edges after the launching edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse: arrays are loaded, begin a scan |
| arrA | input | LEN*DATA_W | First array, element i at [i*DATA_W +: DATA_W] |
| arrB | input | LEN*DATA_W | Second array, same packing |
| minFlat | output | LEN*3*DATA_W | Per-row minimum squares, row k at [k*3*DATA_W +: 3*DATA_W] |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last scan finished |

## Verification
The start pulse is captured on one edge. Row k's result appears LEN*(k+1) edges later, and `done` appears LEN*LEN edges later. With LEN=4, that is edge 4 for row 0 and edge 16 for `done`. The bench drives and samples on falling edges and counts falling edges from the capture. It confirms that a row still holds its old value one edge before its commit and holds the new value just after. It checks that `busy` is still high one edge before completion, and that a start pulse in mid-scan does not move the completion edge.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef struct packed {
    logic valid;   // a pair is being processed this cycle
    logic load;    // first column of a row: restart running minimum
    logic commit;  // last column of a row: write row result
  } pms_strobe_t;
endpackage

// File: rtl/pms_sqdiff.sv
module pms_sqdiff #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [2*DATA_W-1:0] sqOut
);
  logic signed [DATA_W:0]     diffExt;
  logic signed [2*DATA_W+1:0] prodFull;

  always_comb begin
    diffExt  = $signed({opA[DATA_W-1], opA}) - $signed({opB[DATA_W-1], opB});
    prodFull = diffExt * diffExt;
    sqOut    = prodFull[2*DATA_W-1:0];
  end
endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int LEN   = 4,
  parameter int IDX_W = $clog2(LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] rowIdx,
  output logic [IDX_W-1:0] colIdx,
  output pms_strobe_t      strb,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  logic lastCol;
  logic lastPair;

  assign lastCol  = (colIdx == LAST);
  assign lastPair = lastCol && (rowIdx == LAST);

  always_comb begin
    strb.valid  = busy;
    strb.load   = busy && (colIdx == '0);
    strb.commit = busy && lastCol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowIdx <= '0;
      colIdx <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start && !busy) begin
      rowIdx <= '0;
      colIdx <= '0;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      if (lastCol) begin
        colIdx <= '0;
        rowIdx <= rowIdx + 1'b1;
        if (lastPair) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end
  end

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_scan_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && lastCol && !lastPair) |=> (colIdx == '0) && (rowIdx == $past(rowIdx) + 1'b1));

  p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !lastPair) |=> busy);

  p_idle_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && $stable(rowIdx) && $stable(colIdx)));
endmodule

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN    = 4,
  parameter int IDX_W  = $clog2(LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LEN*DATA_W-1:0]   arrA,
  input  logic [LEN*DATA_W-1:0]   arrB,
  input  logic [IDX_W-1:0]        rowIdx,
  input  logic [IDX_W-1:0]        colIdx,
  input  pms_strobe_t             strb,
  output logic [LEN*3*DATA_W-1:0] minFlat
);
  localparam int ACC_W = 3 * DATA_W;
  localparam logic [2*DATA_W-1:0] SQ_MAX = (2*DATA_W)'((2**DATA_W - 1) * (2**DATA_W - 1));

  logic [DATA_W-1:0]       aSel;
  logic [DATA_W-1:0]       bSel;
  logic [2*DATA_W-1:0]     sqVal;
  logic signed [ACC_W-1:0] sqWide;
  logic signed [ACC_W-1:0] runMin;
  logic signed [ACC_W-1:0] candMin;
  logic [ACC_W-1:0]        rowReg [LEN];

  always_comb begin
    aSel = '0;
    bSel = '0;
    for (int i = 0; i < LEN; i++) begin
      if (rowIdx == IDX_W'(i)) aSel = arrA[i*DATA_W +: DATA_W];
      if (colIdx == IDX_W'(i)) bSel = arrB[i*DATA_W +: DATA_W];
    end
  end

  pms_sqdiff #(.DATA_W(DATA_W)) u_sqdiff (
    .opA  (aSel),
    .opB  (bSel),
    .sqOut(sqVal)
  );

  always_comb begin
    sqWide = $signed({{DATA_W{1'b0}}, sqVal});
    if (strb.load)            candMin = sqWide;
    else if (sqWide < runMin) candMin = sqWide;
    else                      candMin = runMin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runMin <= '0;
    end else if (strb.valid) begin
      runMin <= candMin;
    end
  end

  generate
    for (genvar g = 0; g < LEN; g++) begin : g_row
      always_ff @(posedge clk) begin
        if (rst) begin
          rowReg[g] <= '0;
        end else if (strb.commit && (rowIdx == IDX_W'(g))) begin
          rowReg[g] <= candMin;
        end
      end
      assign minFlat[g*ACC_W +: ACC_W] = rowReg[g];
    end
  endgenerate

  p_run_min_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.valid && !strb.load) |=> (runMin <= $past(runMin)));

  p_sq_limit_r5: assert property (@(posedge clk) disable iff (rst)
    strb.valid |-> (sqVal <= SQ_MAX));

  p_rows_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(minFlat));
endmodule

// File: rtl/pair_min_search.sv
module pair_min_search
  import pms_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LEN*DATA_W-1:0]   arrA,
  input  logic [LEN*DATA_W-1:0]   arrB,
  output logic [LEN*3*DATA_W-1:0] minFlat,
  output logic                    busy,
  output logic                    done
);
  localparam int IDX_W = $clog2(LEN + 1);

  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;
  pms_strobe_t      strb;

  pms_ctrl #(.LEN(LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .rowIdx(rowIdx),
    .colIdx(colIdx),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  pms_datapath #(.DATA_W(DATA_W), .LEN(LEN), .IDX_W(IDX_W)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .arrA   (arrA),
    .arrB   (arrB),
    .rowIdx (rowIdx),
    .colIdx (colIdx),
    .strb   (strb),
    .minFlat(minFlat)
  );
endmodule

// File: tb/test_pair_min_search.sv
module test_pair_min_search;
  localparam int DATA_W = 8;
  localparam int LEN    = 4;
  localparam int ACC_W  = 3 * DATA_W;
  localparam int SCAN   = LEN * LEN;
  localparam int NVEC   = 4;

  localparam logic [LEN*DATA_W-1:0] STIM_A [NVEC] = '{
    {8'h04, 8'h03, 8'h02, 8'h01},
    {8'h00, 8'h32, 8'h9C, 8'hFB},
    {8'h00, 8'h80, 8'h7F, 8'h7F},
    {8'hFB, 8'h05, 8'h00, 8'h00}
  };
  localparam logic [LEN*DATA_W-1:0] STIM_B [NVEC] = '{
    {8'h28, 8'h1E, 8'h14, 8'h0A},
    {8'h7F, 8'h80, 8'h07, 8'hFD},
    {8'h80, 8'h80, 8'h80, 8'h80},
    {8'hFD, 8'h03, 8'hFD, 8'h03}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN*DATA_W-1:0] arrA = '0;
  logic [LEN*DATA_W-1:0] arrB = '0;
  logic [LEN*ACC_W-1:0]  minFlat;
  logic busy;
  logic done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pair_min_search #(.DATA_W(DATA_W), .LEN(LEN)) i_pair_min_search (
    .clk(clk), .rst(rst), .start(start), .arrA(arrA), .arrB(arrB),
    .minFlat(minFlat), .busy(busy), .done(done)
  );

  function automatic longint refMin(logic [LEN*DATA_W-1:0] a, logic [LEN*DATA_W-1:0] b, int k);
    longint best = -1;
    for (int l = 0; l < LEN; l++) begin
      longint d = longint'($signed(a[k*DATA_W +: DATA_W])) - longint'($signed(b[l*DATA_W +: DATA_W]));
      if (best < 0 || d * d < best) best = d * d;
    end
    return best;
  endfunction

  function automatic longint rowOf(int k);
    return longint'(minFlat[k*ACC_W +: ACC_W]);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic runVector(int v, string tag);
    arrA = STIM_A[v];
    arrB = STIM_B[v];
    pulseStart();
    repeat (SCAN - 1) @(negedge clk);
    check({tag, " R3 busy before end"}, longint'(busy), 1);
    check({tag, " R3 done before end"}, longint'(done), 0);
    @(negedge clk);
    check({tag, " R3 done at end"}, longint'(done), 1);
    check({tag, " R3 busy at end"}, longint'(busy), 0);
    for (int k = 0; k < LEN; k++) check(tag, rowOf(k), refMin(STIM_A[v], STIM_B[v], k));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 busy", longint'(busy), 0);
    check("R1 done", longint'(done), 0);
    for (int k = 0; k < LEN; k++) check("R1 row", rowOf(k), 0);

    // R2: inputs change while idle, no start
    arrA = STIM_A[1];
    arrB = STIM_B[1];
    repeat (10) @(negedge clk);
    check("R2 busy", longint'(busy), 0);
    check("R2 row0", rowOf(0), 0);

    // table walk (R4; vector 2 carries extremes for R5)
    for (int v = 0; v < NVEC; v++) runVector(v, (v == 2) ? "R5" : "R4");

    // R6: done holds with start low
    repeat (20) @(negedge clk);
    check("R6 done holds", longint'(done), 1);

    // R2: idle inputs change after done, rows unchanged
    arrA = STIM_A[0];
    arrB = STIM_B[0];
    repeat (5) @(negedge clk);
    check("R2 row0 after done", rowOf(0), refMin(STIM_A[3], STIM_B[3], 0));

    // R6 + R8: restart from done; row 0 commits on edge LEN
    pulseStart();
    check("R6 done cleared", longint'(done), 0);
    check("R6 busy set", longint'(busy), 1);
    repeat (LEN - 1) @(negedge clk);
    check("R8 row0 before commit", rowOf(0), refMin(STIM_A[3], STIM_B[3], 0));
    @(negedge clk);
    check("R8 row0 at commit", rowOf(0), refMin(STIM_A[0], STIM_B[0], 0));
    check("R8 row1 untouched", rowOf(1), refMin(STIM_A[3], STIM_B[3], 1));
    repeat (SCAN - LEN) @(negedge clk);
    check("R8 scan done", longint'(done), 1);

    // R7: start pulse mid-scan is ignored
    arrA = STIM_A[1];
    arrB = STIM_B[1];
    pulseStart();
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (SCAN - 7) @(negedge clk);
    check("R7 busy before end", longint'(busy), 1);
    @(negedge clk);
    check("R7 done on time", longint'(done), 1);
    check("R7 row3", rowOf(3), refMin(STIM_A[1], STIM_B[1], 3));

    // R1: reset during a scan
    pulseStart();
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 mid-scan busy", longint'(busy), 0);
    check("R1 mid-scan done", longint'(done), 0);
    check("R1 mid-scan row0", rowOf(0), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule